// File: doc/BRIEF.md
# Single-Precision Exception Response Unit

This block sits at the tail of a single-precision add, subtract, multiply or divide pipeline, after rounding. It receives the rounded result: a sign, a signed exponent that has not been limited to the single-precision range, a 24-bit significand with the hidden bit at the top, and a flag that says whether rounding lost any bits. From these it decides how the result must be delivered. The choices are a plain normal value, a signed zero, a rebiased value for a trap handler, a saturated value, a flushed zero, or a denormal that it rounds again. It then produces the final 32-bit word, the six exception status flags and a one-cycle trap request.

The response path is chosen by a response kind, an enumerated value set once per operation: `K_NORMAL`, `K_ZERO`, `K_TINY_TRAP`, `K_TINY_FLUSH`, `K_TINY_DENORM`, `K_HUGE_TRAP` and `K_HUGE_SAT`. The kind depends on the exponent range, the significand being zero, the overflow and underflow mask bits and the flush-to-zero control. A `unique case` on the kind builds the result and the flags. One register stage holds the outputs, so each response appears one cycle after its valid strobe. The invalid, denormal-operand and divide-by-zero flags are detected upstream and are only passed through.

Top module: `sp_exc_resp`

## Requirements
- R1: With a nonzero significand and an unbiased exponent e in [-126, 127], the result is {sign, e+127, significand bits 22..0}. The precision flag equals the inexact input, and the overflow and underflow flags are clear.
- R2: A result with a nonzero significand is tiny when e < -126 and huge when e > 127. The mask bits and flush control decide only how a tiny or huge result is delivered.
- R3: A huge result with the overflow mask bit (bit 3) clear is returned with biased exponent e+127-192 and the significand bits unchanged. The overflow flag is set, and the precision flag equals the inexact input.
- R4: A huge result with the overflow mask bit set sets both the overflow and precision flags. The result is infinity or the largest finite magnitude, with the input sign, chosen by round_mode: 00 nearest gives infinity, 11 toward zero gives the largest finite value, 10 up gives infinity only for positive, 01 down gives infinity only for negative.
- R5: A tiny result with the underflow mask bit (bit 4) clear is returned with biased exponent e+127+192 and the significand bits unchanged. The underflow flag is set, and the precision flag equals the inexact input. The flush control has no effect in this case.
- R6: A tiny result with the underflow mask bit set and flush control clear is shifted right by -126-e places into the 23-bit denormal field. It is then rounded by round_mode, with the inexact input counted as a sticky bit. A carry out of the field gives the smallest normal value. The underflow and precision flags are both set if any bit was lost and both clear otherwise.
- R7: A tiny result with the underflow mask bit set and flush control set is returned as a zero of the input sign, with both the underflow and precision flags set.
- R8: Flag and mask bit positions: 0 invalid, 1 denormal operand, 2 divide-by-zero, 3 overflow, 4 underflow, 5 precision. Flag bits 2..0 copy in_pass bits 2..0 unchanged.
- R9: out_trap is high, for exactly the cycle in which out_valid is high, when some set output flag has its mask bit clear. Otherwise it is low.
- R10: out_valid rises exactly one cycle after in_valid. out_result and out_flags keep their values while no new operation is presented.
- R11: A zero significand gives a zero of the input sign, with the overflow and underflow flags clear and the precision flag equal to the inexact input.
- R12: After reset, out_valid, out_trap, out_result and out_flags are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: an operation result is present |
| in_sign | input | 1 | Sign of the rounded result |
| in_exp | input | EXP_W (10) | Signed unbiased exponent, not range limited |
| in_sig | input | 24 | Rounded significand, hidden bit at bit 23 |
| in_inexact | input | 1 | Rounding upstream discarded nonzero bits |
| in_pass | input | 3 | Upstream invalid, denormal-operand, divide-by-zero flags |
| exc_mask | input | 6 | Exception mask bits, same layout as the flags |
| ftz_en | input | 1 | Flush tiny masked results to zero |
| round_mode | input | 2 | 00 nearest, 01 down, 10 up, 11 toward zero |
| out_valid | output | 1 | Response present, one cycle after in_valid |
| out_result | output | 32 | Final single-precision word |
| out_flags | output | 6 | Exception status flags |
| out_trap | output | 1 | One-cycle trap request |

## Verification
Directed cases cover each response kind at its boundaries. Exponents of -126 and 127 separate the normal path from the tiny and huge paths. An all-ones significand at exponent -127 shows the rounding carry into the smallest normal. A very small exponent shifts every bit out of the field. The masked overflow case is run under all four rounding modes with both signs, which shows whether infinity and the largest finite value are chosen correctly. The random part sweeps exponents across all three ranges and draws random masks, flush settings, rounding modes and pass-through flags. A reference function predicts each word, flag set and trap, so the random run separates mask-dependent flag behaviour, such as the precision flag under unmasked traps versus masked delivery, from the rounding of denormals.

// File: rtl/sp_exc_pkg.sv
package sp_exc_pkg;
    localparam int FRAC_W    = 23;
    localparam int SIG_W     = FRAC_W + 1;
    localparam int EXP_BIAS  = 127;
    localparam int REBIAS    = 192;
    localparam int EMIN      = -126;
    localparam int EMAX      = 127;
    localparam int MAX_SHIFT = SIG_W + 1;
    localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

    localparam int F_INV = 0;
    localparam int F_DEN = 1;
    localparam int F_DIV = 2;
    localparam int F_OVF = 3;
    localparam int F_UNF = 4;
    localparam int F_PRE = 5;
    localparam int NFLAG = 6;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        K_NORMAL,
        K_ZERO,
        K_TINY_TRAP,
        K_TINY_FLUSH,
        K_TINY_DENORM,
        K_HUGE_TRAP,
        K_HUGE_SAT
    } kind_e;
endpackage

// File: rtl/sp_exc_classify.sv
module sp_exc_classify
    import sp_exc_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic                    sig_nz,
    input  logic                    ovf_masked,
    input  logic                    unf_masked,
    input  logic                    ftz,
    output kind_e                   kind,
    output logic [SHIFT_W-1:0]      shamt
);
    localparam int DW = EXP_W + 2;

    logic signed [DW-1:0] diff;

    always_comb begin
        if (!sig_nz) begin
            kind = K_ZERO;
        end else if (exp_i < EXP_W'(EMIN)) begin
            if (!unf_masked)  kind = K_TINY_TRAP;
            else if (ftz)     kind = K_TINY_FLUSH;
            else              kind = K_TINY_DENORM;
        end else if (exp_i > EXP_W'(EMAX)) begin
            kind = ovf_masked ? K_HUGE_SAT : K_HUGE_TRAP;
        end else begin
            kind = K_NORMAL;
        end
    end

    // distance below the normal range, clamped where every bit is gone
    always_comb begin
        diff = DW'(EMIN) - DW'(exp_i);
        if (diff > DW'(MAX_SHIFT))   shamt = SHIFT_W'(MAX_SHIFT);
        else if (diff < DW'(1))      shamt = SHIFT_W'(1);
        else                         shamt = diff[SHIFT_W-1:0];
    end
endmodule

// File: rtl/sp_exc_denorm.sv
module sp_exc_denorm
    import sp_exc_pkg::*;
(
    input  logic [SIG_W-1:0]   sig,
    input  logic [SHIFT_W-1:0] shamt,
    input  logic               sign,
    input  logic               sticky_in,
    input  logic [1:0]         rmode,
    output logic [30:0]        field,
    output logic               lost
);
    localparam int XW = SIG_W + MAX_SHIFT;

    logic [XW-1:0]    ext;
    logic [SIG_W-1:0] kept;
    logic             guard;
    logic             sticky;
    logic             rnd_up;

    always_comb begin
        ext    = {sig, {MAX_SHIFT{1'b0}}} >> shamt;
        kept   = ext[XW-1:MAX_SHIFT];
        guard  = ext[MAX_SHIFT-1];
        sticky = (|ext[MAX_SHIFT-2:0]) | sticky_in;
        unique case (rmode_e'(rmode))
            RM_NEAR: rnd_up = guard & (sticky | kept[0]);
            RM_DOWN: rnd_up = sign & (guard | sticky);
            RM_UP:   rnd_up = ~sign & (guard | sticky);
            RM_ZERO: rnd_up = 1'b0;
        endcase
        field = 31'(kept) + 31'(rnd_up);
        lost  = guard | sticky;
    end
endmodule

// File: rtl/sp_exc_resp.sv
module sp_exc_resp
    import sp_exc_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [23:0]             in_sig,
    input  logic                    in_inexact,
    input  logic [2:0]              in_pass,
    input  logic [5:0]              exc_mask,
    input  logic                    ftz_en,
    input  logic [1:0]              round_mode,
    output logic                    out_valid,
    output logic [31:0]             out_result,
    output logic [5:0]              out_flags,
    output logic                    out_trap
);
    localparam int DW = EXP_W + 2;

    kind_e                kind;
    logic [SHIFT_W-1:0]   shamt;
    logic [30:0]          dn_field;
    logic                 dn_lost;
    logic signed [DW-1:0] e_norm, e_tiny, e_huge;
    logic                 to_inf;
    logic                 f_ovf, f_unf, f_pre;
    logic [31:0]          res_d;
    logic [NFLAG-1:0]     flags_d;
    logic                 trap_d;

    sp_exc_classify #(.EXP_W(EXP_W)) u_class (
        .exp_i      (in_exp),
        .sig_nz     (|in_sig),
        .ovf_masked (exc_mask[F_OVF]),
        .unf_masked (exc_mask[F_UNF]),
        .ftz        (ftz_en),
        .kind       (kind),
        .shamt      (shamt)
    );

    sp_exc_denorm u_denorm (
        .sig       (in_sig),
        .shamt     (shamt),
        .sign      (in_sign),
        .sticky_in (in_inexact),
        .rmode     (round_mode),
        .field     (dn_field),
        .lost      (dn_lost)
    );

    always_comb begin
        e_norm = DW'(in_exp) + DW'(EXP_BIAS);
        e_tiny = e_norm + DW'(REBIAS);
        e_huge = e_norm - DW'(REBIAS);
        unique case (rmode_e'(round_mode))
            RM_NEAR: to_inf = 1'b1;
            RM_DOWN: to_inf = in_sign;
            RM_UP:   to_inf = ~in_sign;
            RM_ZERO: to_inf = 1'b0;
        endcase
    end

    // response selection per kind
    always_comb begin
        f_ovf = 1'b0;
        f_unf = 1'b0;
        f_pre = in_inexact;
        unique case (kind)
            K_NORMAL:      res_d = {in_sign, e_norm[7:0], in_sig[FRAC_W-1:0]};
            K_ZERO:        res_d = {in_sign, 31'b0};
            K_TINY_TRAP: begin
                res_d = {in_sign, e_tiny[7:0], in_sig[FRAC_W-1:0]};
                f_unf = 1'b1;
            end
            K_TINY_FLUSH: begin
                res_d = {in_sign, 31'b0};
                f_unf = 1'b1;
                f_pre = 1'b1;
            end
            K_TINY_DENORM: begin
                res_d = {in_sign, dn_field};
                f_unf = dn_lost;
                f_pre = dn_lost;
            end
            K_HUGE_TRAP: begin
                res_d = {in_sign, e_huge[7:0], in_sig[FRAC_W-1:0]};
                f_ovf = 1'b1;
            end
            K_HUGE_SAT: begin
                res_d = to_inf ? {in_sign, 8'hFF, 23'h000000}
                               : {in_sign, 8'hFE, 23'h7FFFFF};
                f_ovf = 1'b1;
                f_pre = 1'b1;
            end
            default:       res_d = {in_sign, 31'b0};
        endcase
        flags_d = {f_pre, f_unf, f_ovf, in_pass};
        trap_d  = in_valid & (|(flags_d & ~exc_mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_trap   <= 1'b0;
            out_result <= '0;
            out_flags  <= '0;
        end else begin
            out_valid <= in_valid;
            out_trap  <= trap_d;
            if (in_valid) begin
                out_result <= res_d;
                out_flags  <= flags_d;
            end
        end
    end
endmodule

// File: rtl/sp_exc_resp_chk.sv
module sp_exc_resp_chk #(
    parameter int EXP_W = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic signed [EXP_W-1:0] in_exp,
    input logic [23:0]             in_sig,
    input logic [2:0]              in_pass,
    input logic [5:0]              exc_mask,
    input logic                    ftz_en,
    input logic                    out_valid,
    input logic [31:0]             out_result,
    input logic [5:0]              out_flags,
    input logic                    out_trap
);
    logic tiny_in;
    assign tiny_in = (in_sig != 24'd0) && (in_exp < EXP_W'(-126));

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> out_valid == $past(in_valid));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result) && $stable(out_flags));

    p_trap_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_trap |-> out_valid);

    p_trap_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_trap == (|(out_flags & ~$past(exc_mask))));

    p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_flags[2:0] == $past(in_pass));

    p_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_flags[3] && $past(exc_mask[3])
            |-> out_result[30:24] == 7'h7F && out_flags[5]);

    p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(tiny_in && ftz_en && exc_mask[4])
            |-> out_result[30:0] == 31'd0 && out_flags[4] && out_flags[5]);
endmodule

bind sp_exc_resp sp_exc_resp_chk #(.EXP_W(EXP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_exp     (in_exp),
    .in_sig     (in_sig),
    .in_pass    (in_pass),
    .exc_mask   (exc_mask),
    .ftz_en     (ftz_en),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_flags  (out_flags),
    .out_trap   (out_trap)
);

// File: tb/sp_exc_resp_test.sv
module sp_exc_resp_test;
    localparam int CLK_PERIOD = 10;
    localparam int EXP_W = 10;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic                    in_sign = 1'b0;
    logic signed [EXP_W-1:0] in_exp = '0;
    logic [23:0]             in_sig = '0;
    logic                    in_inexact = 1'b0;
    logic [2:0]              in_pass = '0;
    logic [5:0]              exc_mask = '0;
    logic                    ftz_en = 1'b0;
    logic [1:0]              round_mode = '0;
    logic                    out_valid;
    logic [31:0]             out_result;
    logic [5:0]              out_flags;
    logic                    out_trap;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sp_exc_resp #(.EXP_W(EXP_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig(in_sig), .in_inexact(in_inexact),
        .in_pass(in_pass), .exc_mask(exc_mask), .ftz_en(ftz_en),
        .round_mode(round_mode), .out_valid(out_valid),
        .out_result(out_result), .out_flags(out_flags), .out_trap(out_trap)
    );

    // reference: returns {trap, flags[5:0], result[31:0]}
    function automatic logic [38:0] model(input logic s, input int e,
            input logic [23:0] sg, input logic inx, input logic [2:0] ps,
            input logic [5:0] mk, input logic fz, input logic [1:0] rm);
        logic [31:0] r;
        logic ov, un, pr, inf, g, st, up;
        logic [5:0] f;
        int d;
        ov = 0; un = 0; pr = inx;
        if (sg == 24'd0) begin
            r = {s, 31'd0};
        end else if (e > 127) begin
            ov = 1;
            if (!mk[3]) begin
                r = {s, 8'(e + 127 - 192), sg[22:0]};
            end else begin
                pr = 1;
                case (rm)
                    2'b00: inf = 1'b1;
                    2'b01: inf = s;
                    2'b10: inf = !s;
                    default: inf = 1'b0;
                endcase
                r = inf ? {s, 31'h7F800000} : {s, 31'h7F7FFFFF};
            end
        end else if (e < -126) begin
            if (!mk[4]) begin
                un = 1;
                r = {s, 8'(e + 127 + 192), sg[22:0]};
            end else if (fz) begin
                un = 1; pr = 1;
                r = {s, 31'd0};
            end else begin
                d = int'(sg); g = 0; st = inx;
                for (int i = 0; i < -126 - e; i++) begin
                    st = st | g;
                    g = d[0];
                    d = d >> 1;
                end
                case (rm)
                    2'b00: up = g & (st | d[0]);
                    2'b01: up = s & (g | st);
                    2'b10: up = !s & (g | st);
                    default: up = 1'b0;
                endcase
                d = d + int'(up);
                r = {s, 31'(d)};
                un = g | st;
                pr = un;
            end
        end else begin
            r = {s, 8'(e + 127), sg[22:0]};
        end
        f = {pr, un, ov, ps};
        return {|(f & ~mk), f, r};
    endfunction

    function automatic string tag_of(input int e, input logic [23:0] sg,
            input logic [5:0] mk, input logic fz);
        if (sg == 24'd0) return "R11";
        if (e > 127) return mk[3] ? "R4" : "R3";
        if (e < -126) begin
            if (!mk[4]) return "R5";
            return fz ? "R7" : "R6";
        end
        return "R1";
    endfunction

    task automatic check(input string tag, input logic [38:0] act,
            input logic [38:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    // drive one operation, sample the response one cycle later
    task automatic apply(input string tag, input logic s, input int e,
            input logic [23:0] sg, input logic inx, input logic [2:0] ps,
            input logic [5:0] mk, input logic fz, input logic [1:0] rm);
        @(negedge clk);
        in_valid = 1; in_sign = s; in_exp = EXP_W'(e); in_sig = sg;
        in_inexact = inx; in_pass = ps; exc_mask = mk; ftz_en = fz;
        round_mode = rm;
        @(negedge clk);
        in_valid = 0;
        check({tag, "/R10 valid"}, {38'd0, out_valid}, 39'd1);
        check(tag, {out_trap, out_flags, out_result},
              model(s, e, sg, inx, ps, mk, fz, rm));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", {out_trap, out_valid, out_flags, out_result}, 40'd0);
        rst_n = 1;

        // R1 literal: 1.0
        apply("R1", 0, 0, 24'h800000, 0, 3'b0, 6'h3F, 0, 2'b00);
        check("R1 literal", {7'd0, out_result}, {7'd0, 32'h3F800000});
        apply("R1", 1, -126, 24'hABCDEF, 1, 3'b0, 6'h1F, 0, 2'b00);
        apply("R1", 0, 127, 24'hFFFFFF, 0, 3'b0, 6'h00, 0, 2'b00);
        // R2 boundaries just outside
        apply("R2", 0, 128, 24'h800000, 0, 3'b0, 6'h00, 0, 2'b00);
        apply("R2", 0, -127, 24'h800001, 0, 3'b0, 6'h00, 0, 2'b00);
        // R3 unmasked overflow
        apply("R3", 1, 200, 24'hC00000, 1, 3'b0, 6'h37, 0, 2'b01);
        // R4 masked overflow, all modes and both signs
        for (int m = 0; m < 4; m++) begin
            apply("R4", 0, 150, 24'h900000, 0, 3'b0, 6'h3F, 0, 2'(m));
            apply("R4", 1, 150, 24'h900000, 0, 3'b0, 6'h3F, 0, 2'(m));
        end
        apply("R4", 0, 140, 24'h800000, 0, 3'b0, 6'h3F, 0, 2'b00);
        check("R4 literal", {7'd0, out_result}, {7'd0, 32'h7F800000});
        // R5 unmasked underflow, flush ignored
        apply("R5", 0, -140, 24'h812345, 0, 3'b0, 6'h2F, 1, 2'b00);
        apply("R5", 1, -200, 24'hF00000, 1, 3'b0, 6'h0F, 0, 2'b00);
        // R6 masked denormal: exact, inexact, carry, all bits lost
        apply("R6", 0, -127, 24'h800000, 0, 3'b0, 6'h3F, 0, 2'b00);
        apply("R6", 0, -127, 24'hFFFFFF, 0, 3'b0, 6'h3F, 0, 2'b00);
        check("R6 carry", {7'd0, out_result}, {7'd0, 32'h00800000});
        apply("R6", 1, -130, 24'h8000F3, 0, 3'b0, 6'h1F, 0, 2'b01);
        apply("R6", 0, -149, 24'hC00000, 0, 3'b0, 6'h3F, 0, 2'b00);
        apply("R6", 0, -300, 24'h800000, 0, 3'b0, 6'h3F, 0, 2'b10);
        apply("R6", 1, -300, 24'h800000, 0, 3'b0, 6'h3F, 0, 2'b11);
        // R7 flush to zero
        apply("R7", 1, -130, 24'h800000, 0, 3'b0, 6'h3F, 1, 2'b00);
        apply("R7", 0, -150, 24'hFFFFFF, 0, 3'b0, 6'h1F, 1, 2'b00);
        // R8 pass-through, R9 trap from passed flag
        apply("R8", 0, 5, 24'h800000, 0, 3'b101, 6'h3F, 0, 2'b00);
        apply("R9", 0, 5, 24'h800000, 0, 3'b100, 6'h3B, 0, 2'b00);
        apply("R11", 1, 0, 24'h000000, 0, 3'b0, 6'h00, 0, 2'b00);
        // R10/R9: idle cycle keeps outputs, trap and valid low
        begin
            logic [37:0] held;
            held = {out_flags, out_result};
            @(negedge clk);
            check("R10 hold", {1'b0, out_flags, out_result}, {1'b0, held});
            check("R9 idle", {37'd0, out_trap, out_valid}, 39'd0);
        end

        void'($urandom(32'd4242));
        for (int n = 0; n < 400; n++) begin
            int e;
            logic [23:0] sg;
            logic [5:0] mk;
            logic fz;
            e = int'($urandom_range(400)) - 200;
            sg = ($urandom_range(15) == 0) ? 24'd0 : {1'b1, 23'($urandom)};
            mk = 6'($urandom);
            fz = 1'($urandom);
            apply(tag_of(e, sg, mk, fz), 1'($urandom), e, sg, 1'($urandom),
                  3'($urandom), mk, fz, 2'($urandom));
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule